// File: doc/BRIEF.md
# Memory Channel Init Sequencer

The sequencer brings a chain of memory devices out of power-on or reset. It drives a fixed, ordered script of control-register transactions into a serial-interface master. When `start_i` is accepted it first waits a programmable pause. It then sends a serial reset and clears a test register to zero. Next it programs the channel cycle time, converted from picoseconds into 64 ps units. After that it enumerates every device twice. The first pass gives each device its serial ID, counting up from the nearest device. The second pass gives each device its memory device ID, taken from a per-position map that the system supplies so that devices of the same core configuration can be grouped. The script ends with the powerdown-exit pair, the nap-exit timing, the two read-latency registers at their minimum values, and the row-to-column timing register.

Each transaction goes through a two-step handshake. The request is held until the serial master accepts it with `req_ready_i`. The sequencer then waits for a completion pulse on `ack_i` before it builds the next request. `done_o` rises once the last completion arrives. It stays high until the next run is started. Clock generation and later latency tuning belong to other blocks.

Top module: `chan_bringup_seq`

## Requirements
- R1: After a synchronous reset, `req_valid_o` and `done_o` are both 0 and no request is issued until `start_i` is seen.
- R2: After `start_i` is accepted, the first request appears between PAUSE_CYC and PAUSE_CYC+3 cycles later. It is the serial reset: `req_op_o`=0, with address, device and data all 0. No other request is issued before that reset has been accepted.
- R3: A request stays valid, with its fields unchanged, until `req_ready_i` is seen. After acceptance `req_valid_o` stays low until `ack_i` has been seen, so only one transaction is ever outstanding.
- R4: The second transaction is a broadcast write (`req_op_o`=1) of 0 to register 0x10.
- R5: The third transaction is a broadcast write to register 0x11. Its data is the picosecond period rounded up to whole 64 ps units: ceil(`cyc_ps_i`/64).
- R6: Next come N directed writes (`req_op_o`=2) to register 0x12. For i = 0 to N-1 in ascending order, each has `req_dev_o`=i and data i.
- R7: Next come N directed writes to register 0x13. For i = 0 to N-1 in ascending order, each has `req_dev_o`=i and data equal to `devid_map_i[5*i +: 5]`.
- R8: Next come broadcast writes in this order: `pdx_i` to 0x14, `pdxa_i` to 0x15, then `napx_i` to 0x16.
- R9: Last come broadcast writes in this order: `rdlat_min_i` to 0x17, `rddly_min_i` to 0x18, then `rowcol_i` to 0x19.
- R10: N is the value of `dev_count_i` sampled when the run starts, capped at MAX_DEV. Later changes to `dev_count_i` have no effect on the run. N=0 drops both enumeration passes.
- R11: `done_o` rises on the cycle after the `ack_i` of the final transaction. It stays high with no request until the next accepted start clears it.
- R12: `start_i` asserted while a run is in progress is ignored. The transaction stream continues unchanged, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a bring-up run (taken only when idle) |
| dev_count_i | input | 6 | Number of devices on the chain |
| cyc_ps_i | input | 16 | Channel clock period in picoseconds |
| devid_map_i | input | 160 | Device ID for chain position i at bits [5i+4:5i] |
| pdx_i | input | 16 | Powerdown-exit timing value |
| pdxa_i | input | 16 | Second powerdown-exit timing value |
| napx_i | input | 16 | Nap-exit timing value |
| rdlat_min_i | input | 16 | Minimum read-latency value |
| rddly_min_i | input | 16 | Minimum read-delay value |
| rowcol_i | input | 16 | Row-to-column timing value |
| req_valid_o | output | 1 | Request to the serial master |
| req_ready_i | input | 1 | Serial master accepts the request |
| ack_i | input | 1 | Serial master finished the accepted transaction |
| req_op_o | output | 2 | 0 reset, 1 broadcast write, 2 directed write |
| req_dev_o | output | 5 | Target serial ID for directed writes |
| req_addr_o | output | 8 | Register address |
| req_data_o | output | 16 | Write data |
| done_o | output | 1 | Bring-up finished |

## Verification
The assertions check the following on every cycle:
- A pending request holds steady while it waits for ready.
- No request is visible during the pause or while a completion is awaited.
- Nothing precedes the serial reset.
- `done_o` never coincides with a request.
- A busy start never sends the machine back into the pause.
- The pause counter counts down by exactly one per cycle.

Only the bench's scenarios can show the content and order of the script. This covers the rounded cycle-time value, the ascending serial and device ID passes taken from the map, skipping both passes for an empty chain, capping the count, and running to completion while a busy start is ignored.

// File: rtl/bringup_pkg.sv
package bringup_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PAUSE, ST_RESET, ST_TESTZ, ST_CYC, ST_SID, ST_DID,
    ST_PDX, ST_PDXA, ST_NAPX, ST_RDLAT, ST_RDDLY, ST_ROWCOL
  } step_e;

  typedef enum logic [1:0] {PH_LOAD, PH_HOLD, PH_ACKW} phase_e;

  localparam logic [1:0] OP_RESET  = 2'd0;
  localparam logic [1:0] OP_BCAST  = 2'd1;
  localparam logic [1:0] OP_DIRECT = 2'd2;

  localparam int AW = 8;
  localparam logic [AW-1:0] A_TESTZ  = 8'h10;
  localparam logic [AW-1:0] A_CYC    = 8'h11;
  localparam logic [AW-1:0] A_SID    = 8'h12;
  localparam logic [AW-1:0] A_DID    = 8'h13;
  localparam logic [AW-1:0] A_PDX    = 8'h14;
  localparam logic [AW-1:0] A_PDXA   = 8'h15;
  localparam logic [AW-1:0] A_NAPX   = 8'h16;
  localparam logic [AW-1:0] A_RDLAT  = 8'h17;
  localparam logic [AW-1:0] A_RDDLY  = 8'h18;
  localparam logic [AW-1:0] A_ROWCOL = 8'h19;
endpackage

// File: rtl/bringup_pause.sv
module bringup_pause #(
  parameter int PAUSE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = $clog2(PAUSE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(PAUSE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2: the pause elapses one step per cycle, never faster
  assert_pause_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/bringup_payload.sv
module bringup_payload
  import bringup_pkg::*;
#(
  parameter int MAX_DEV = 32,
  parameter int DW      = 16,
  parameter int IDW     = 5
) (
  input  step_e                 step_i,
  input  logic [IDW-1:0]        idx_i,
  input  logic [DW-1:0]         cyc_ps_i,
  input  logic [MAX_DEV*IDW-1:0] devid_map_i,
  input  logic [DW-1:0]         pdx_i,
  input  logic [DW-1:0]         pdxa_i,
  input  logic [DW-1:0]         napx_i,
  input  logic [DW-1:0]         rdlat_min_i,
  input  logic [DW-1:0]         rddly_min_i,
  input  logic [DW-1:0]         rowcol_i,
  output logic [1:0]            op_o,
  output logic [IDW-1:0]        dev_o,
  output logic [AW-1:0]         addr_o,
  output logic [DW-1:0]         data_o
);
  logic [IDW-1:0] dev_tbl [MAX_DEV];
  logic [DW:0]    cyc_units;

  for (genvar g = 0; g < MAX_DEV; g++) begin : g_unpack
    assign dev_tbl[g] = devid_map_i[g*IDW +: IDW];
  end

  // round the period up to whole 64 ps units
  assign cyc_units = ({1'b0, cyc_ps_i} + (DW+1)'(63)) >> 6;

  always_comb begin
    op_o   = OP_BCAST;
    dev_o  = '0;
    addr_o = '0;
    data_o = '0;
    unique case (step_i)
      ST_RESET:  op_o = OP_RESET;
      ST_TESTZ:  addr_o = A_TESTZ;
      ST_CYC:    begin addr_o = A_CYC;   data_o = cyc_units[DW-1:0]; end
      ST_SID:    begin op_o = OP_DIRECT; dev_o = idx_i; addr_o = A_SID;
                       data_o = DW'(idx_i); end
      ST_DID:    begin op_o = OP_DIRECT; dev_o = idx_i; addr_o = A_DID;
                       data_o = DW'(dev_tbl[idx_i]); end
      ST_PDX:    begin addr_o = A_PDX;    data_o = pdx_i;       end
      ST_PDXA:   begin addr_o = A_PDXA;   data_o = pdxa_i;      end
      ST_NAPX:   begin addr_o = A_NAPX;   data_o = napx_i;      end
      ST_RDLAT:  begin addr_o = A_RDLAT;  data_o = rdlat_min_i; end
      ST_RDDLY:  begin addr_o = A_RDDLY;  data_o = rddly_min_i; end
      ST_ROWCOL: begin addr_o = A_ROWCOL; data_o = rowcol_i;    end
      default:   ;
    endcase
  end
endmodule

// File: rtl/chan_bringup_seq.sv
module chan_bringup_seq
  import bringup_pkg::*;
#(
  parameter int MAX_DEV   = 32,
  parameter int DW        = 16,
  parameter int PAUSE_CYC = 200,
  localparam int IDW      = $clog2(MAX_DEV),
  localparam int CNTW     = $clog2(MAX_DEV + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [CNTW-1:0]        dev_count_i,
  input  logic [DW-1:0]          cyc_ps_i,
  input  logic [MAX_DEV*IDW-1:0] devid_map_i,
  input  logic [DW-1:0]          pdx_i,
  input  logic [DW-1:0]          pdxa_i,
  input  logic [DW-1:0]          napx_i,
  input  logic [DW-1:0]          rdlat_min_i,
  input  logic [DW-1:0]          rddly_min_i,
  input  logic [DW-1:0]          rowcol_i,
  output logic                   req_valid_o,
  input  logic                   req_ready_i,
  input  logic                   ack_i,
  output logic [1:0]             req_op_o,
  output logic [IDW-1:0]         req_dev_o,
  output logic [AW-1:0]          req_addr_o,
  output logic [DW-1:0]          req_data_o,
  output logic                   done_o
);
  step_e          st_q;
  phase_e         ph_q;
  logic [IDW-1:0] idx_q;
  logic [CNTW-1:0] cnt_q;
  logic           pause_done;
  logic           go;
  logic [1:0]     p_op;
  logic [IDW-1:0] p_dev;
  logic [AW-1:0]  p_addr;
  logic [DW-1:0]  p_data;
  logic           last_dev;

  assign go       = (st_q == ST_IDLE) && start_i;
  assign last_dev = ({1'b0, idx_q} + 1'b1) >= (IDW+1)'(cnt_q);

  function automatic step_e step_after(step_e s, logic empty);
    case (s)
      ST_RESET:  return ST_TESTZ;
      ST_TESTZ:  return ST_CYC;
      ST_CYC:    return empty ? ST_PDX : ST_SID;
      ST_SID:    return ST_DID;
      ST_DID:    return ST_PDX;
      ST_PDX:    return ST_PDXA;
      ST_PDXA:   return ST_NAPX;
      ST_NAPX:   return ST_RDLAT;
      ST_RDLAT:  return ST_RDDLY;
      ST_RDDLY:  return ST_ROWCOL;
      default:   return ST_IDLE;
    endcase
  endfunction

  bringup_pause #(.PAUSE_CYC(PAUSE_CYC)) i_pause (
    .clk(clk), .rst(rst), .load_i(go), .expired_o(pause_done));

  bringup_payload #(.MAX_DEV(MAX_DEV), .DW(DW), .IDW(IDW)) i_payload (
    .step_i(st_q), .idx_i(idx_q), .cyc_ps_i(cyc_ps_i), .devid_map_i(devid_map_i),
    .pdx_i(pdx_i), .pdxa_i(pdxa_i), .napx_i(napx_i), .rdlat_min_i(rdlat_min_i),
    .rddly_min_i(rddly_min_i), .rowcol_i(rowcol_i),
    .op_o(p_op), .dev_o(p_dev), .addr_o(p_addr), .data_o(p_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;  ph_q <= PH_LOAD;  idx_q <= '0;  cnt_q <= '0;
      req_valid_o <= 1'b0;  req_op_o <= '0;  req_dev_o <= '0;
      req_addr_o <= '0;  req_data_o <= '0;  done_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_PAUSE;
          done_o <= 1'b0;
          idx_q  <= '0;
          cnt_q  <= (dev_count_i > CNTW'(MAX_DEV)) ? CNTW'(MAX_DEV) : dev_count_i;
        end
        ST_PAUSE: if (pause_done) begin
          st_q <= ST_RESET;
          ph_q <= PH_LOAD;
        end
        default: begin
          unique case (ph_q)
            PH_LOAD: begin
              req_valid_o <= 1'b1;
              req_op_o    <= p_op;
              req_dev_o   <= p_dev;
              req_addr_o  <= p_addr;
              req_data_o  <= p_data;
              ph_q        <= PH_HOLD;
            end
            PH_HOLD: if (req_ready_i) begin
              req_valid_o <= 1'b0;
              ph_q        <= PH_ACKW;
            end
            default: if (ack_i) begin
              ph_q <= PH_LOAD;
              if (st_q == ST_ROWCOL) begin
                st_q   <= ST_IDLE;
                done_o <= 1'b1;
              end else if ((st_q == ST_SID || st_q == ST_DID) && !last_dev) begin
                idx_q <= idx_q + 1'b1;
              end else begin
                idx_q <= '0;
                st_q  <= step_after(st_q, cnt_q == '0);
              end
            end
          endcase
        end
      endcase
    end
  end

  // ---- assertion support: has the serial reset been accepted this run
  logic rst_seen;
  always_ff @(posedge clk) begin
    if (rst || go) rst_seen <= 1'b0;
    else if (req_valid_o && req_ready_i && req_op_o == OP_RESET) rst_seen <= 1'b1;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_op_o) &&
      $stable(req_dev_o) && $stable(req_addr_o) && $stable(req_data_o)));

  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ACKW && st_q != ST_IDLE && st_q != ST_PAUSE) |-> !req_valid_o);

  assert_reset_first_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_op_o == OP_RESET || rst_seen));

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAUSE) |-> !req_valid_o);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_valid_o);

  assert_busy_start_R12: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && start_i) |=> (st_q != ST_PAUSE || $past(st_q) == ST_PAUSE));
endmodule

// File: tb/test_chan_bringup_seq.sv
module test_chan_bringup_seq;
  localparam int MAX_DEV = 32;
  localparam int DW      = 16;
  localparam int PAUSE   = 200;
  localparam int IDW     = 5;
  localparam int CNTW    = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start_i, req_ready_i, ack_i;
  logic [CNTW-1:0] dev_count_i;
  logic [DW-1:0] cyc_ps_i, pdx_i, pdxa_i, napx_i, rdlat_min_i, rddly_min_i, rowcol_i;
  logic [MAX_DEV*IDW-1:0] devid_map_i;
  logic req_valid_o, done_o;
  logic [1:0] req_op_o;
  logic [IDW-1:0] req_dev_o;
  logic [7:0] req_addr_o;
  logic [DW-1:0] req_data_o;

  chan_bringup_seq #(.MAX_DEV(MAX_DEV), .DW(DW), .PAUSE_CYC(PAUSE)) i_chan_bringup_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .dev_count_i(dev_count_i),
    .cyc_ps_i(cyc_ps_i), .devid_map_i(devid_map_i), .pdx_i(pdx_i), .pdxa_i(pdxa_i),
    .napx_i(napx_i), .rdlat_min_i(rdlat_min_i), .rddly_min_i(rddly_min_i),
    .rowcol_i(rowcol_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .ack_i(ack_i), .req_op_o(req_op_o), .req_dev_o(req_dev_o),
    .req_addr_o(req_addr_o), .req_data_o(req_data_o), .done_o(done_o));

  int compared = 0, mismatched = 0, cyc = 0;
  int map_ref [MAX_DEV];
  logic [30:0] expq [$];

  function automatic logic [30:0] pk(int op, int dev, int addr, int data);
    return {op[1:0], dev[4:0], addr[7:0], data[15:0]};
  endfunction

  function automatic string tag_of(logic [30:0] t);
    case (t[23:16])
      8'h00: return "R2";  8'h10: return "R4";  8'h11: return "R5";
      8'h12: return "R6";  8'h13: return "R7";
      8'h14, 8'h15, 8'h16: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // reference script, built from the requirements (R4..R10)
  task automatic build(int n_in, int ps);
    int n = (n_in > MAX_DEV) ? MAX_DEV : n_in;   // R10 cap
    expq.delete();
    expq.push_back(pk(0, 0, 8'h00, 0));
    expq.push_back(pk(1, 0, 8'h10, 0));
    expq.push_back(pk(1, 0, 8'h11, (ps + 63) / 64));
    for (int i = 0; i < n; i++) expq.push_back(pk(2, i, 8'h12, i));
    for (int i = 0; i < n; i++) expq.push_back(pk(2, i, 8'h13, map_ref[i]));
    expq.push_back(pk(1, 0, 8'h14, int'(pdx_i)));
    expq.push_back(pk(1, 0, 8'h15, int'(pdxa_i)));
    expq.push_back(pk(1, 0, 8'h16, int'(napx_i)));
    expq.push_back(pk(1, 0, 8'h17, int'(rdlat_min_i)));
    expq.push_back(pk(1, 0, 8'h18, int'(rddly_min_i)));
    expq.push_back(pk(1, 0, 8'h19, int'(rowcol_i)));
  endtask

  task automatic run(int n, int ps, bit poke, int rdy_dly, int ack_dly);
    int k;
    logic [30:0] got, exp;
    @(negedge clk);
    dev_count_i = CNTW'(n);
    cyc_ps_i    = DW'(ps);
    build(n, ps);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) dev_count_i = 6'd1;        // R10: change after start has no effect
    k = 1;
    while (!req_valid_o && k < PAUSE + 50) begin
      @(negedge clk);
      k++;
    end
    chk(k >= PAUSE && k <= PAUSE + 3, "R2", "pause length", k, PAUSE);
    while (expq.size() > 0) begin
      exp = expq.pop_front();
      k = 0;
      while (!req_valid_o && k < 1000) begin
        chk(done_o == 1'b0, "R11", "done while busy", done_o, 0);
        @(negedge clk);
        k++;
      end
      got = {req_op_o, req_dev_o, req_addr_o, req_data_o};
      for (int d = 0; d < rdy_dly; d++) begin
        @(negedge clk);
        chk(req_valid_o && {req_op_o, req_dev_o, req_addr_o, req_data_o} == got,
            "R3", "hold before ready", {req_valid_o, req_op_o, req_dev_o, req_addr_o, req_data_o},
            {1'b1, got});
      end
      chk(got == exp, tag_of(exp), "transaction", got, exp);
      req_ready_i = 1'b1;
      @(negedge clk);
      req_ready_i = 1'b0;
      if (poke) start_i = 1'b1;          // R12: start while busy
      for (int d = 0; d < ack_dly; d++) begin
        chk(req_valid_o == 1'b0, "R3", "valid before ack", req_valid_o, 0);
        @(negedge clk);
        start_i = 1'b0;
      end
      chk(req_valid_o == 1'b0, "R3", "valid before ack", req_valid_o, 0);
      start_i = 1'b0;
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
    end
    chk(done_o == 1'b1, "R11", "done after last ack", done_o, 1);
  endtask

  task automatic idle_watch(int cycles, string req);
    bit bad = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (req_valid_o || !done_o) bad = 1;
    end
    chk(!bad, req, "idle after run (valid/done)", {req_valid_o, done_o}, 2'b01);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; req_ready_i = 1'b0; ack_i = 1'b0;
    dev_count_i = '0; cyc_ps_i = '0;
    pdx_i = 16'h0123; pdxa_i = 16'h0456; napx_i = 16'h0789;
    rdlat_min_i = 16'h0003; rddly_min_i = 16'h0002; rowcol_i = 16'h0007;
    for (int i = 0; i < MAX_DEV; i++) begin
      map_ref[i] = (i * 11 + 5) % 32;
      devid_map_i[i*IDW +: IDW] = IDW'(map_ref[i]);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_valid_o == 1'b0 && done_o == 1'b0, "R1", "reset state",
        {req_valid_o, done_o}, 0);
    repeat (20) @(negedge clk);
    chk(req_valid_o == 1'b0, "R1", "no request without start", req_valid_o, 0);

    run(3, 2500, 1'b0, 0, 0);            // R5 rounding up: 2500 ps -> 40
    idle_watch(10, "R11");
    run(0, 1280, 1'b0, 2, 3);            // R10 empty chain, R5 exact: 20
    run(40, 938, 1'b1, 1, 2);            // R10 cap to 32, R12 busy starts
    idle_watch(PAUSE + 20, "R12");       // no second run was queued
    pdx_i = 16'h0A0B; rowcol_i = 16'h0011;
    run(5, 63, 1'b0, 3, 1);              // R8 R9 new values, R5 63 ps -> 1
    idle_watch(5, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule